// File: doc/BRIEF.md
# Mode-Load and DLL Lock Tracker

This block watches the mode-register and extended-mode-register load strobes of a DDR-style memory interface. It captures the burst length and CAS latency that software programs, and it follows the DLL through enable, reset and lock. It raises one-cycle warning flags when a load carries an illegal encoding, breaks the required sequence, or arrives while a bank is still open.

The DLL is enabled or disabled through bit 0 of an extended load. A mode load with bit 8 set then starts a DLL reset, which lasts a fixed number of clocks, `LOCK_CYCLES`. The lock flag rises when that interval ends. Two loads must be at least `MRD_CYCLES` clock edges apart. Both intervals are parameters counted in clock cycles.

A controller or a protocol monitor uses the flags to check its own sequencing. The latched burst length and CAS latency can drive the controller's timing.

Top module: `mrs_dll_tracker`

## Requirements
- R1: After reset the burst length reads 2, the CAS latency reads 4 half-cycles, the DLL is disabled and unlocked, and every warning flag is low.
- R2: A mode load whose burst-length field (address bits 2:0) holds 001, 010 or 011 sets `burst_len_o` to 2, 4 or 8 from the next clock edge on.
- R3: A mode load whose CAS field (address bits 6:4) holds 010 or 110 sets `cas_half_o` to 4 (latency 2.0) or to 5 (latency 2.5).
- R4: Any other burst-length or CAS code pulses `warn_bl_o` or `warn_cl_o` in the cycle after the load, and the affected value keeps its previous setting. The two fields are judged independently.
- R5: An extended load is accepted only when `banks_idle_i` is high and no mode load is present in the same cycle. When accepted, address bit 0 = 0 enables the DLL and 1 disables it. A disable also clears the lock flag and stops any running lock count.
- R6: A mode load with the DLL enabled, address bit 8 clear, and no DLL reset issued since the last accepted extended load pulses `warn_no_rst_o`.
- R7: A mode load with the DLL disabled and address bit 8 set pulses `warn_ign_rst_o` and starts no lock count.
- R8: A mode load with the DLL enabled and address bit 8 set clears the lock flag. The lock flag then rises exactly `LOCK_CYCLES` (default 200) clock edges after that load's edge. A mode load without bit 8 during the count does not disturb it.
- R9: Any load while `banks_idle_i` is low pulses `warn_busy_o`. The mode-load fields are still captured.
- R10: A load that arrives fewer than `MRD_CYCLES` (default 2) clock edges after the previous load of either kind pulses `warn_mrd_o`.
- R11: Mode and extended loads in the same cycle pulse `warn_mrd_o`. The extended load is dropped and the mode load is processed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_ld_i | input | 1 | Mode-register load strobe |
| ext_ld_i | input | 1 | Extended-mode-register load strobe |
| addr_i | input | ADDR_W | Address bus carrying the load value |
| banks_idle_i | input | 1 | All banks precharged |
| burst_len_o | output | 4 | Latched burst length (2, 4 or 8) |
| cas_half_o | output | 3 | Latched CAS latency in half cycles |
| dll_en_o | output | 1 | DLL enabled |
| dll_locked_o | output | 1 | DLL reset interval complete |
| warn_bl_o | output | 1 | Illegal burst-length code |
| warn_cl_o | output | 1 | Illegal CAS code |
| warn_no_rst_o | output | 1 | DLL enabled but reset missing |
| warn_ign_rst_o | output | 1 | Reset requested with DLL disabled |
| warn_busy_o | output | 1 | Load while a bank is open |
| warn_mrd_o | output | 1 | Load spacing or collision error |

## Verification
The assertions hold on every cycle for these properties:
- the latched burst length and CAS latency are always legal values;
- an encoding warning never coincides with a change of the value it concerns;
- lock only exists with the DLL enabled;
- the lock flag rises exactly `LOCK_CYCLES` edges after a reset start;
- an ignored-reset warning only appears with the DLL disabled.

Only the bench's scenarios show the finer behaviour:
- the code-to-value decoding;
- the conditions for the missing-reset warning;
- that a mid-count mode load leaves the lock interval intact;
- the tMRD spacing boundary;
- the treatment of colliding strobes.

// File: rtl/mrs_pkg.sv
package mrs_pkg;

  localparam int DLL_OFF_BIT = 0;
  localparam int DLL_RST_BIT = 8;

  typedef struct packed {
    logic bl;
    logic cl;
    logic no_rst;
    logic ign_rst;
    logic busy;
    logic mrd;
  } warn_t;

  function automatic logic bl_ok(input logic [2:0] code);
    return (code == 3'b001) || (code == 3'b010) || (code == 3'b011);
  endfunction

  function automatic logic [3:0] bl_val(input logic [2:0] code);
    logic [3:0] v;
    case (code)
      3'b010:  v = 4'd4;
      3'b011:  v = 4'd8;
      default: v = 4'd2;
    endcase
    return v;
  endfunction

  function automatic logic cl_ok(input logic [2:0] code);
    return (code == 3'b010) || (code == 3'b110);
  endfunction

  function automatic logic [2:0] cl_half(input logic [2:0] code);
    return (code == 3'b110) ? 3'd5 : 3'd4;
  endfunction

endpackage

// File: rtl/mrs_rst_sync.sv
module mrs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/mrs_field_reg.sv
module mrs_field_reg
  import mrs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_i,
  input  logic [2:0] bl_code_i,
  input  logic [2:0] cl_code_i,
  output logic [3:0] burst_len_o,
  output logic [2:0] cas_half_o,
  output logic       bl_bad_o,
  output logic       cl_bad_o
);
  logic [3:0] bl_q, bl_n;
  logic [2:0] cl_q, cl_n;
  logic       blw_q, blw_n, clw_q, clw_n;

  always_comb begin
    bl_n  = bl_q;
    cl_n  = cl_q;
    blw_n = 1'b0;
    clw_n = 1'b0;
    if (load_i) begin
      if (bl_ok(bl_code_i)) bl_n = bl_val(bl_code_i);
      else                  blw_n = 1'b1;
      if (cl_ok(cl_code_i)) cl_n = cl_half(cl_code_i);
      else                  clw_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bl_q  <= 4'd2;
      cl_q  <= 3'd4;
      blw_q <= 1'b0;
      clw_q <= 1'b0;
    end else begin
      bl_q  <= bl_n;
      cl_q  <= cl_n;
      blw_q <= blw_n;
      clw_q <= clw_n;
    end
  end

  assign burst_len_o = bl_q;
  assign cas_half_o  = cl_q;
  assign bl_bad_o    = blw_q;
  assign cl_bad_o    = clw_q;
endmodule

// File: rtl/mrs_dll_ctrl.sv
module mrs_dll_ctrl #(
  parameter int LOCK_CYCLES = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_take_i,
  input  logic off_bit_i,
  input  logic mode_take_i,
  input  logic rst_bit_i,
  output logic dll_en_o,
  output logic locked_o,
  output logic no_rst_o,
  output logic ign_rst_o
);
  localparam int CW = $clog2(LOCK_CYCLES + 1);
  localparam logic [CW-1:0] LOCK_LAST = CW'(LOCK_CYCLES);

  logic          en_q, en_n, lock_q, lock_n, act_q, act_n, seen_q, seen_n;
  logic          nr_q, nr_n, ig_q, ig_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          restart, kill;

  always_comb begin
    en_n    = en_q;
    lock_n  = lock_q;
    act_n   = act_q;
    cnt_n   = cnt_q;
    seen_n  = seen_q;
    nr_n    = 1'b0;
    ig_n    = 1'b0;
    restart = 1'b0;
    kill    = 1'b0;
    if (ext_take_i) begin
      en_n   = ~off_bit_i;
      seen_n = 1'b0;
      kill   = off_bit_i;
    end else if (mode_take_i) begin
      if (en_q && rst_bit_i) begin
        restart = 1'b1;
        seen_n  = 1'b1;
      end else if (en_q && !seen_q && !rst_bit_i) begin
        nr_n = 1'b1;
      end else if (!en_q && rst_bit_i) begin
        ig_n = 1'b1;
      end
    end
    if (kill) begin
      lock_n = 1'b0;
      act_n  = 1'b0;
      cnt_n  = '0;
    end else if (restart) begin
      lock_n = 1'b0;
      act_n  = 1'b1;
      cnt_n  = '0;
    end else if (act_q) begin
      cnt_n = cnt_q + 1'b1;
      if (cnt_n == LOCK_LAST) begin
        lock_n = 1'b1;
        act_n  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      lock_q <= 1'b0;
      act_q  <= 1'b0;
      cnt_q  <= '0;
      seen_q <= 1'b0;
      nr_q   <= 1'b0;
      ig_q   <= 1'b0;
    end else begin
      en_q   <= en_n;
      lock_q <= lock_n;
      act_q  <= act_n;
      cnt_q  <= cnt_n;
      seen_q <= seen_n;
      nr_q   <= nr_n;
      ig_q   <= ig_n;
    end
  end

  assign dll_en_o  = en_q;
  assign locked_o  = lock_q;
  assign no_rst_o  = nr_q;
  assign ign_rst_o = ig_q;
endmodule

// File: rtl/mrs_seq_check.sv
module mrs_seq_check #(
  parameter int MRD_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_ld_i,
  input  logic ext_ld_i,
  input  logic idle_i,
  output logic busy_o,
  output logic mrd_o
);
  localparam int SW = $clog2(MRD_CYCLES + 1);
  localparam logic [SW-1:0] GAP_OK = SW'(MRD_CYCLES - 1);

  logic [SW-1:0] since_q, since_n;
  logic          busy_q, busy_n, mrd_q, mrd_n;
  logic          any_ld;

  assign any_ld = mode_ld_i | ext_ld_i;

  always_comb begin
    busy_n  = any_ld & ~idle_i;
    mrd_n   = (any_ld & (since_q < GAP_OK)) | (mode_ld_i & ext_ld_i);
    since_n = since_q;
    if (any_ld)                since_n = '0;
    else if (since_q < GAP_OK) since_n = since_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= GAP_OK;
      busy_q  <= 1'b0;
      mrd_q   <= 1'b0;
    end else begin
      since_q <= since_n;
      busy_q  <= busy_n;
      mrd_q   <= mrd_n;
    end
  end

  assign busy_o = busy_q;
  assign mrd_o  = mrd_q;
endmodule

// File: rtl/mrs_dll_tracker.sv
module mrs_dll_tracker
  import mrs_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int LOCK_CYCLES = 200,
  parameter int MRD_CYCLES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_ld_i,
  input  logic              ext_ld_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              banks_idle_i,
  output logic [3:0]        burst_len_o,
  output logic [2:0]        cas_half_o,
  output logic              dll_en_o,
  output logic              dll_locked_o,
  output logic              warn_bl_o,
  output logic              warn_cl_o,
  output logic              warn_no_rst_o,
  output logic              warn_ign_rst_o,
  output logic              warn_busy_o,
  output logic              warn_mrd_o
);
  logic  rst_s_n;
  logic  ext_take;
  warn_t warn;

  mrs_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_s_n)
  );

  assign ext_take = ext_ld_i & ~mode_ld_i & banks_idle_i;

  mrs_field_reg u_fld (
    .clk(clk), .rst_n(rst_s_n), .load_i(mode_ld_i),
    .bl_code_i(addr_i[2:0]), .cl_code_i(addr_i[6:4]),
    .burst_len_o(burst_len_o), .cas_half_o(cas_half_o),
    .bl_bad_o(warn.bl), .cl_bad_o(warn.cl)
  );

  mrs_dll_ctrl #(.LOCK_CYCLES(LOCK_CYCLES)) u_dll (
    .clk(clk), .rst_n(rst_s_n),
    .ext_take_i(ext_take), .off_bit_i(addr_i[DLL_OFF_BIT]),
    .mode_take_i(mode_ld_i), .rst_bit_i(addr_i[DLL_RST_BIT]),
    .dll_en_o(dll_en_o), .locked_o(dll_locked_o),
    .no_rst_o(warn.no_rst), .ign_rst_o(warn.ign_rst)
  );

  mrs_seq_check #(.MRD_CYCLES(MRD_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_s_n), .mode_ld_i(mode_ld_i), .ext_ld_i(ext_ld_i),
    .idle_i(banks_idle_i), .busy_o(warn.busy), .mrd_o(warn.mrd)
  );

  assign warn_bl_o      = warn.bl;
  assign warn_cl_o      = warn.cl;
  assign warn_no_rst_o  = warn.no_rst;
  assign warn_ign_rst_o = warn.ign_rst;
  assign warn_busy_o    = warn.busy;
  assign warn_mrd_o     = warn.mrd;
endmodule

// File: rtl/mrs_dll_tracker_chk.sv
module mrs_dll_tracker_chk #(
  parameter int ADDR_W      = 13,
  parameter int LOCK_CYCLES = 200
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_ld_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [3:0]        burst_len_o,
  input logic [2:0]        cas_half_o,
  input logic              dll_en_o,
  input logic              dll_locked_o,
  input logic              warn_bl_o,
  input logic              warn_cl_o,
  input logic              warn_ign_rst_o
);
  localparam int CW = $clog2(LOCK_CYCLES + 2);
  logic [CW-1:0] since_rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst_q <= CW'(LOCK_CYCLES + 1);
    else if (mode_ld_i && dll_en_o && addr_i[8]) since_rst_q <= '0;
    else if (since_rst_q <= CW'(LOCK_CYCLES)) since_rst_q <= since_rst_q + 1'b1;
  end

  AST_BL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_len_o == 4'd2) || (burst_len_o == 4'd4) || (burst_len_o == 4'd8)); // R2
  AST_CL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_half_o == 3'd4) || (cas_half_o == 3'd5)); // R3
  AST_BL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    warn_bl_o |-> (burst_len_o == $past(burst_len_o))); // R4
  AST_CL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    warn_cl_o |-> (cas_half_o == $past(cas_half_o))); // R4
  AST_LOCK_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    dll_locked_o |-> dll_en_o); // R5
  AST_IGN_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    warn_ign_rst_o |-> !dll_en_o); // R7
  AST_LOCK_INTERVAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dll_locked_o) |-> (since_rst_q == CW'(LOCK_CYCLES))); // R8
endmodule

bind mrs_dll_tracker mrs_dll_tracker_chk #(.ADDR_W(ADDR_W), .LOCK_CYCLES(LOCK_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_ld_i(mode_ld_i), .addr_i(addr_i),
  .burst_len_o(burst_len_o), .cas_half_o(cas_half_o), .dll_en_o(dll_en_o),
  .dll_locked_o(dll_locked_o), .warn_bl_o(warn_bl_o), .warn_cl_o(warn_cl_o),
  .warn_ign_rst_o(warn_ign_rst_o)
);

// File: tb/sim_mrs_dll_tracker.sv
`timescale 1ns/1ps
module sim_mrs_dll_tracker;
  localparam int LOCK = 200;

  logic        clk = 1'b0;
  logic        rst_n, mode_ld, ext_ld, idle;
  logic [12:0] addr;
  logic [3:0]  bl;
  logic [2:0]  cl;
  logic        en, lk, w_bl, w_cl, w_nr, w_ig, w_busy, w_mrd;
  int          n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  mrs_dll_tracker #(.ADDR_W(13), .LOCK_CYCLES(LOCK), .MRD_CYCLES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_ld_i(mode_ld), .ext_ld_i(ext_ld),
    .addr_i(addr), .banks_idle_i(idle), .burst_len_o(bl), .cas_half_o(cl),
    .dll_en_o(en), .dll_locked_o(lk), .warn_bl_o(w_bl), .warn_cl_o(w_cl),
    .warn_no_rst_o(w_nr), .warn_ign_rst_o(w_ig), .warn_busy_o(w_busy),
    .warn_mrd_o(w_mrd)
  );

  function automatic logic [12:0] mk(input logic [2:0] b, input logic [2:0] c,
                                     input logic r8, input logic d0);
    logic [12:0] a = '0;
    a[2:0] = b; a[6:4] = c; a[8] = r8; a[0] = a[0] | d0;
    return a;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int warns();
    return {w_bl, w_cl, w_nr, w_ig, w_busy, w_mrd};
  endfunction

  task automatic pulse(input logic m, input logic e, input logic [12:0] a);
    mode_ld = m; ext_ld = e; addr = a;
    @(posedge clk);
    @(negedge clk);
    mode_ld = 1'b0; ext_ld = 1'b0;
  endtask

  task automatic gap();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 bl", bl, 2); chk("R1 cl", cl, 4);
    chk("R1 en", en, 0); chk("R1 lock", lk, 0); chk("R1 warns", warns(), 0);
  endtask

  task automatic t_fields();
    pulse(1, 0, mk(3'b010, 3'b110, 0, 0));
    chk("R2 bl4", bl, 4); chk("R3 cl5", cl, 5); chk("R2 nowarn", warns(), 0); gap();
    pulse(1, 0, mk(3'b011, 3'b010, 0, 0));
    chk("R2 bl8", bl, 8); chk("R3 cl4", cl, 4); gap();
    pulse(1, 0, mk(3'b001, 3'b010, 0, 0));
    chk("R2 bl2", bl, 2); gap();
    pulse(1, 0, mk(3'b011, 3'b110, 0, 0)); gap();
  endtask

  task automatic t_illegal();
    pulse(1, 0, mk(3'b000, 3'b110, 0, 0));
    chk("R4 bl warn", w_bl, 1); chk("R4 cl quiet", w_cl, 0); chk("R4 bl held", bl, 8);
    gap();
    chk("R4 pulse ends", w_bl, 0);
    pulse(1, 0, mk(3'b010, 3'b011, 0, 0));
    chk("R4 cl warn", w_cl, 1); chk("R4 cl held", cl, 5); chk("R4 bl indep", bl, 4);
    gap();
    pulse(1, 0, mk(3'b111, 3'b111, 0, 0));
    chk("R4 both", {w_bl, w_cl}, 3); chk("R4 bl held2", bl, 4); gap();
  endtask

  task automatic t_mrd();
    pulse(1, 0, mk(3'b010, 3'b110, 0, 0));
    chk("R10 first ok", w_mrd, 0);
    pulse(1, 0, mk(3'b010, 3'b110, 0, 0));
    chk("R10 too close", w_mrd, 1);
    gap();
    pulse(1, 0, mk(3'b010, 3'b110, 0, 0));
    chk("R10 spaced ok", w_mrd, 0); gap();
  endtask

  task automatic t_busy_and_ext();
    idle = 1'b0;
    pulse(0, 1, mk(3'b000, 3'b000, 0, 0));
    chk("R9 busy ext", w_busy, 1); chk("R5 ext refused", en, 0); gap();
    pulse(1, 0, mk(3'b011, 3'b110, 0, 0));
    chk("R9 busy mode", w_busy, 1); chk("R9 fields latch", bl, 8); gap();
    idle = 1'b1;
    pulse(1, 0, mk(3'b011, 3'b110, 1, 0));
    chk("R7 ignored reset", w_ig, 1); chk("R7 no lock", lk, 0); gap();
    repeat (LOCK + 5) @(posedge clk);
    @(negedge clk);
    chk("R7 no count", lk, 0);
    pulse(0, 1, mk(3'b000, 3'b000, 0, 0));
    chk("R5 enabled", en, 1); chk("R5 no busy", w_busy, 0); gap();
  endtask

  task automatic t_lock();
    pulse(1, 0, mk(3'b011, 3'b110, 0, 0));
    chk("R6 missing reset", w_nr, 1); gap();
    pulse(1, 0, mk(3'b011, 3'b110, 1, 0));
    chk("R8 start unlocked", lk, 0); chk("R6 no warn on reset", w_nr, 0);
    repeat (49) @(posedge clk);
    @(negedge clk);
    pulse(1, 0, mk(3'b010, 3'b110, 0, 0));
    chk("R6 reset seen", w_nr, 0); chk("R8 mid-count", lk, 0);
    repeat (149) @(posedge clk);
    @(negedge clk);
    chk("R8 edge 199", lk, 0);
    @(posedge clk);
    @(negedge clk);
    chk("R8 edge 200", lk, 1);
    pulse(0, 1, mk(3'b000, 3'b000, 0, 0));
    chk("R5 stays en", en, 1); gap();
    pulse(1, 0, mk(3'b010, 3'b110, 0, 0));
    chk("R6 after new ext", w_nr, 1); gap();
  endtask

  task automatic t_collide_and_off();
    pulse(1, 1, mk(3'b001, 3'b010, 0, 1));
    chk("R11 mrd", w_mrd, 1); chk("R11 ext dropped", en, 1); chk("R11 mode done", bl, 2);
    gap();
    pulse(0, 1, mk(3'b000, 3'b000, 0, 1));
    chk("R5 disabled", en, 0); chk("R5 lock cleared", lk, 0); gap();
  endtask

  initial begin
    rst_n = 1'b0; mode_ld = 1'b0; ext_ld = 1'b0; addr = '0; idle = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    t_reset();
    t_fields();
    t_illegal();
    t_mrd();
    t_busy_and_ext();
    t_lock();
    t_collide_and_off();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule